// File: doc/BRIEF.md
# Transactional Cache Conflict Controller

This block is a small fully associative data cache for one core of a snooping multiprocessor, extended so that it can hold the speculative state of a hardware transaction. Each way stores an address tag, one data word, a coherence state (Invalid, Shared or Modified) and a transactional flag. While a transaction is open, every line the core reads or writes is flagged, so the cache itself holds the transaction's read set and write set. Line data is written in place; a local write to a line already present upgrades it to Modified and puts nothing on the bus.

The core opens a transaction with a begin command and closes it with a commit command. A successful commit clears every flag in one cycle. It then announces each line that the transaction left Modified on a broadcast port, one address per cycle, lowest way first. Other cores' commits arrive on a snoop port. If a snooped address matches a flagged line, the local transaction is aborted with a conflict reason. A transactional miss that finds every way flagged aborts with a capacity reason.

An abort invalidates all flagged lines and leaves unflagged lines as they were. Restarting the transaction and restoring registers is left to the core, which polls the outcome with a validate command.

Top module: `tx_cache_ctl`

## Requirements
- R1: After reset every way is Invalid, no transaction is open, no abort is pending, `req_ready` is 1, and `rsp_valid`, `bus_rd_req`, `bc_valid`, `val_valid` and `cmt_valid` are 0. A read after reset therefore misses.
- R2: A read that hits returns the stored word on `rsp_rdata` with `rsp_valid` one cycle after acceptance, and `bus_rd_req` stays low.
- R3: A read miss raises `bus_rd_req` with the request address from the cycle after acceptance. The request and address hold until the cycle in which `bus_fill_valid` is sampled. The line is then installed Shared (flagged if a transaction is open), and the fill word is returned with `rsp_valid` one cycle later.
- R4: A write that hits updates the word, sets the line Modified (flagged if a transaction is open), returns the written word one cycle after acceptance, and issues no bus request.
- R5: A write miss fetches the line like a read miss, then installs it Modified holding the written word, and returns that word one cycle after the fill.
- R6: A commit while a transaction is open gives `cmt_valid`=1 and `cmt_ok`=1 one cycle later. It clears all flags. From that same cycle, each line that was flagged and Modified is presented on `bc_addr`/`bc_data` with `bc_valid`, one per cycle in ascending way index. `req_ready` is 0 while `bc_valid` is 1, and committed lines stay readable afterwards.
- R7: A snooped address that matches a flagged line while a transaction is open aborts it with reason code 1 (conflict). All flagged lines become Invalid (later reads miss), and unflagged lines still hit with their data.
- R8: A snooped address that matches an unflagged line invalidates only that line and raises no abort.
- R9: A miss inside an open transaction with every way flagged aborts with reason code 2 (capacity). It issues no bus request, answers with `rsp_valid` one cycle after acceptance and `rsp_rdata`=0, and invalidates the flagged lines.
- R10: A validate command gives `val_valid`=1 one cycle later, with `val_abort` showing whether an abort is pending and `val_reason` holding its code (0 none, 1 conflict, 2 capacity). A begin command clears a pending abort.
- R11: A commit when no transaction is open (never begun, or aborted) gives `cmt_valid`=1 with `cmt_ok`=0 and broadcasts nothing.
- R12: A fill is placed in the lowest-index Invalid way. If no way is Invalid, it replaces the lowest-index way that is not flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Requests and commands are accepted in this cycle |
| rsp_valid | output | 1 | Access completed |
| rsp_rdata | output | DW | Read or written word |
| cmd_begin | input | 1 | Open a transaction |
| cmd_commit | input | 1 | Commit the open transaction |
| cmd_validate | input | 1 | Query the abort status |
| val_valid | output | 1 | Validate answer present |
| val_abort | output | 1 | Abort pending |
| val_reason | output | 2 | Abort reason code |
| cmt_valid | output | 1 | Commit answer present |
| cmt_ok | output | 1 | Commit succeeded |
| bus_rd_req | output | 1 | Line fetch request, held until fill |
| bus_rd_addr | output | AW | Line fetch address |
| bus_fill_valid | input | 1 | Fill word present |
| bus_fill_data | input | DW | Fill word |
| bc_valid | output | 1 | Commit broadcast entry present |
| bc_addr | output | AW | Committed address |
| bc_data | output | DW | Committed word |
| snp_valid | input | 1 | Remote commit address present |
| snp_addr | input | AW | Remote committed address |

## Verification
Hits, capacity aborts and both command answers are due one cycle after the acceptance edge. A miss shows `bus_rd_req` one cycle after acceptance, and its response comes one cycle after the edge that samples the fill. The bench drives every input at a falling edge and samples at the next falling edge, so it reads each result exactly in its due cycle. A missing or late response is reported rather than waited for. Broadcast entries are collected on consecutive falling edges starting with the commit answer, which checks their count, order and data together with `req_ready` being held low.

// File: rtl/tx_cache_ctl.sv
module tx_cache_ctl #(
  parameter int WAYS = 4,
  parameter int AW   = 16,
  parameter int DW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  input  logic          cmd_begin,
  input  logic          cmd_commit,
  input  logic          cmd_validate,
  output logic          val_valid,
  output logic          val_abort,
  output logic [1:0]    val_reason,
  output logic          cmt_valid,
  output logic          cmt_ok,
  output logic          bus_rd_req,
  output logic [AW-1:0] bus_rd_addr,
  input  logic          bus_fill_valid,
  input  logic [DW-1:0] bus_fill_data,
  output logic          bc_valid,
  output logic [AW-1:0] bc_addr,
  output logic [DW-1:0] bc_data,
  input  logic          snp_valid,
  input  logic [AW-1:0] snp_addr
);

  localparam int WIDX = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2;
  localparam logic [1:0] WHY_NONE = 2'd0, WHY_CONFLICT = 2'd1, WHY_CAPACITY = 2'd2;

  logic [AW-1:0]   tag_q [WAYS];
  logic [DW-1:0]   dat_q [WAYS];
  logic [1:0]      st_q  [WAYS];
  logic [WAYS-1:0] txf_q;
  logic [WAYS-1:0] bc_q;

  logic            tx_q, abt_q, filling_q, pend_wr_q;
  logic [1:0]      why_q;
  logic [AW-1:0]   pend_addr_q;
  logic [DW-1:0]   pend_wdata_q;

  logic [WAYS-1:0] vld, hit_vec, snp_vec, dirty;

  function automatic logic [WIDX-1:0] lowest(input logic [WAYS-1:0] v);
    logic [WIDX-1:0] r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--)
      if (v[i]) r = WIDX'(i);
    return r;
  endfunction

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign vld[w]     = (st_q[w] != ST_I);
    assign hit_vec[w] = vld[w] && (tag_q[w] == req_addr);
    assign snp_vec[w] = vld[w] && (tag_q[w] == snp_addr);
    assign dirty[w]   = (st_q[w] == ST_M);
  end

  logic            hit, victim_ok, busy, go;
  logic            acc_begin, acc_commit, acc_val, acc_req;
  logic            cap_fail, conflict, abort_now, start_fill, fill_done;
  logic [WIDX-1:0] hit_way, victim, bc_way;

  assign hit        = |hit_vec;
  assign hit_way    = lowest(hit_vec);
  assign victim_ok  = |(~txf_q);
  assign victim     = (|(~vld)) ? lowest(~vld) : lowest(~txf_q);

  assign busy       = filling_q || (|bc_q);
  assign req_ready  = !busy && !snp_valid;
  assign go         = req_ready;
  assign acc_begin  = go && cmd_begin;
  assign acc_commit = go && cmd_commit && !cmd_begin;
  assign acc_val    = go && cmd_validate && !cmd_begin && !cmd_commit;
  assign acc_req    = go && req_valid && !cmd_begin && !cmd_commit && !cmd_validate;

  assign cap_fail   = acc_req && !hit && tx_q && !victim_ok;
  assign conflict   = snp_valid && tx_q && (|(snp_vec & txf_q));
  assign abort_now  = conflict || cap_fail;
  assign start_fill = acc_req && !hit && !cap_fail;
  assign fill_done  = filling_q && bus_fill_valid;

  assign bus_rd_req  = filling_q;
  assign bus_rd_addr = pend_addr_q;

  assign bc_way   = lowest(bc_q);
  assign bc_valid = |bc_q;
  assign bc_addr  = tag_q[bc_way];
  assign bc_data  = dat_q[bc_way];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) begin
        st_q[w]  <= ST_I;
        tag_q[w] <= '0;
        dat_q[w] <= '0;
      end
      txf_q <= '0;
    end else begin
      for (int w = 0; w < WAYS; w++) begin
        if (abort_now && txf_q[w]) st_q[w] <= ST_I;
        if (snp_valid && snp_vec[w]) st_q[w] <= ST_I;
      end
      if (abort_now || acc_commit) txf_q <= '0;
      if (acc_req && hit) begin
        if (req_write) begin
          dat_q[hit_way] <= req_wdata;
          st_q[hit_way]  <= ST_M;
        end
        if (tx_q) txf_q[hit_way] <= 1'b1;
      end
      if (fill_done) begin
        tag_q[victim] <= pend_addr_q;
        dat_q[victim] <= pend_wr_q ? pend_wdata_q : bus_fill_data;
        st_q[victim]  <= pend_wr_q ? ST_M : ST_S;
        txf_q[victim] <= tx_q && !abort_now;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q         <= 1'b0;
      abt_q        <= 1'b0;
      why_q        <= WHY_NONE;
      filling_q    <= 1'b0;
      pend_wr_q    <= 1'b0;
      pend_addr_q  <= '0;
      pend_wdata_q <= '0;
      bc_q         <= '0;
      rsp_valid    <= 1'b0;
      rsp_rdata    <= '0;
      val_valid    <= 1'b0;
      val_abort    <= 1'b0;
      val_reason   <= WHY_NONE;
      cmt_valid    <= 1'b0;
      cmt_ok       <= 1'b0;
    end else begin
      if (acc_begin) begin
        tx_q  <= 1'b1;
        abt_q <= 1'b0;
        why_q <= WHY_NONE;
      end else if (abort_now) begin
        tx_q  <= 1'b0;
        abt_q <= 1'b1;
        why_q <= conflict ? WHY_CONFLICT : WHY_CAPACITY;
      end else if (acc_commit) begin
        tx_q <= 1'b0;
      end

      if (start_fill) begin
        filling_q    <= 1'b1;
        pend_wr_q    <= req_write;
        pend_addr_q  <= req_addr;
        pend_wdata_q <= req_wdata;
      end else if (fill_done) begin
        filling_q <= 1'b0;
      end

      if (acc_commit && tx_q) bc_q <= txf_q & dirty;
      else                    bc_q <= bc_q & (bc_q - 1'b1);

      rsp_valid <= (acc_req && hit) || cap_fail || fill_done;
      if (acc_req && hit)  rsp_rdata <= req_write ? req_wdata : dat_q[hit_way];
      else if (cap_fail)   rsp_rdata <= '0;
      else if (fill_done)  rsp_rdata <= pend_wr_q ? pend_wdata_q : bus_fill_data;

      val_valid  <= acc_val;
      val_abort  <= abt_q;
      val_reason <= why_q;
      cmt_valid  <= acc_commit;
      cmt_ok     <= acc_commit && tx_q;
    end
  end

endmodule

module tx_cache_ctl_chk #(
  parameter int WAYS = 4,
  parameter int AW   = 16,
  parameter int WIDX = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            bus_rd_req,
  input logic [AW-1:0]   bus_rd_addr,
  input logic            bus_fill_valid,
  input logic            bc_valid,
  input logic [WIDX-1:0] bc_way,
  input logic            cmt_valid,
  input logic            cmt_ok,
  input logic [WAYS-1:0] txf_q,
  input logic            tx_q,
  input logic            abt_q,
  input logic [1:0]      why_q
);

  a_r3_fill_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_req && !bus_fill_valid |=> bus_rd_req && $stable(bus_rd_addr));

  a_r2_rsp_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !bus_rd_req);

  a_r6_bc_blocks_core: assert property (@(posedge clk) disable iff (!rst_n)
    bc_valid |-> !req_ready);

  a_r6_bc_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    bc_valid |=> !bc_valid || (bc_way > $past(bc_way)));

  a_r7_abort_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abt_q) |-> (txf_q == '0) && !tx_q);

  a_r8_no_abort_outside_tx: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_q |=> !$rose(abt_q));

  a_r9_capacity_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abt_q) && (why_q == 2'd2) |-> !bus_rd_req);

  a_r11_failed_commit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid && !cmt_ok |-> !bc_valid);

endmodule

bind tx_cache_ctl tx_cache_ctl_chk #(.WAYS(WAYS), .AW(AW), .WIDX(WIDX)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .bus_rd_req(bus_rd_req), .bus_rd_addr(bus_rd_addr), .bus_fill_valid(bus_fill_valid),
  .bc_valid(bc_valid), .bc_way(bc_way), .cmt_valid(cmt_valid), .cmt_ok(cmt_ok),
  .txf_q(txf_q), .tx_q(tx_q), .abt_q(abt_q), .why_q(why_q)
);

// File: tb/tb_tx_cache_ctl.sv
module tb_tx_cache_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 27;
  localparam logic [2:0] OP_RD = 3'd0, OP_WR = 3'd1, OP_BEG = 3'd2,
                         OP_CMT = 3'd3, OP_VAL = 3'd4, OP_SNP = 3'd5;

  // fields: op, requirement number, address, write data, expect miss, expected value
  localparam logic [55:0] VEC [NVEC] = '{
    {OP_RD,  4'd3,  16'h0010, 16'h0000, 1'b1, 16'h5A4A},  // R3 cold miss
    {OP_RD,  4'd2,  16'h0010, 16'h0000, 1'b0, 16'h5A4A},  // R2 hit
    {OP_WR,  4'd4,  16'h0010, 16'h1111, 1'b0, 16'h1111},  // R4 write hit
    {OP_RD,  4'd4,  16'h0010, 16'h0000, 1'b0, 16'h1111},
    {OP_WR,  4'd5,  16'h0020, 16'h2222, 1'b1, 16'h2222},  // R5 write miss
    {OP_RD,  4'd5,  16'h0020, 16'h0000, 1'b0, 16'h2222},
    {OP_SNP, 4'd8,  16'h0020, 16'h0000, 1'b0, 16'h0000},  // R8 snoop unflagged
    {OP_RD,  4'd8,  16'h0020, 16'h0000, 1'b1, 16'h5A7A},
    {OP_RD,  4'd8,  16'h0010, 16'h0000, 1'b0, 16'h1111},
    {OP_BEG, 4'd10, 16'h0000, 16'h0000, 1'b0, 16'h0000},
    {OP_VAL, 4'd10, 16'h0000, 16'h0000, 1'b0, 16'h0000},  // R10 none pending
    {OP_RD,  4'd7,  16'h0020, 16'h0000, 1'b0, 16'h5A7A},
    {OP_WR,  4'd5,  16'h0030, 16'h3333, 1'b1, 16'h3333},
    {OP_SNP, 4'd7,  16'h0020, 16'h0000, 1'b0, 16'h0000},  // R7 conflict
    {OP_VAL, 4'd7,  16'h0000, 16'h0000, 1'b0, 16'h0005},  // pending, code 1
    {OP_RD,  4'd7,  16'h0030, 16'h0000, 1'b1, 16'h5A6A},  // flagged line gone
    {OP_RD,  4'd7,  16'h0010, 16'h0000, 1'b0, 16'h1111},  // unflagged kept
    {OP_CMT, 4'd11, 16'h0000, 16'h0000, 1'b0, 16'h0000},  // R11 failed commit
    {OP_BEG, 4'd10, 16'h0000, 16'h0000, 1'b0, 16'h0000},
    {OP_WR,  4'd4,  16'h0010, 16'hAAAA, 1'b0, 16'hAAAA},
    {OP_WR,  4'd5,  16'h0040, 16'h4444, 1'b1, 16'h4444},
    {OP_RD,  4'd2,  16'h0030, 16'h0000, 1'b0, 16'h5A6A},
    {OP_CMT, 4'd6,  16'h0000, 16'h0000, 1'b0, 16'h0021},  // R6 ok, two entries
    {OP_VAL, 4'd10, 16'h0000, 16'h0000, 1'b0, 16'h0000},
    {OP_SNP, 4'd8,  16'h0030, 16'h0000, 1'b0, 16'h0000},
    {OP_VAL, 4'd8,  16'h0000, 16'h0000, 1'b0, 16'h0000},
    {OP_RD,  4'd6,  16'h0040, 16'h0000, 1'b0, 16'h4444}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic cmd_begin = 1'b0, cmd_commit = 1'b0, cmd_validate = 1'b0;
  logic val_valid, val_abort, cmt_valid, cmt_ok;
  logic [1:0] val_reason;
  logic bus_rd_req, bus_fill_valid = 1'b0;
  logic [15:0] bus_rd_addr, bus_fill_data = '0;
  logic bc_valid;
  logic [15:0] bc_addr, bc_data;
  logic snp_valid = 1'b0;
  logic [15:0] snp_addr = '0;

  int checks = 0, fails = 0, cyc = 0;
  int bc_n;
  logic [15:0] bc_a [8];
  logic [15:0] bc_d [8];

  tx_cache_ctl #(.WAYS(4), .AW(16), .DW(16)) dut (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [15:0] a, input logic [15:0] d,
                        output logic miss, output logic resp, output logic [15:0] rd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    miss = bus_rd_req;
    if (bus_rd_req) begin
      chk("R3", 32'(bus_rd_addr), 32'(a), "fetch address");
      @(negedge clk);
      chk("R3", 32'(bus_rd_req), 32'd1, "fetch held");
      bus_fill_valid = 1'b1; bus_fill_data = a ^ 16'h5A5A;
      @(negedge clk);
      bus_fill_valid = 1'b0;
    end
    resp = rsp_valid;
    rd = rsp_rdata;
  endtask

  task automatic command(input logic [2:0] op, output logic got, output logic [2:0] res);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cmd_begin = (op == OP_BEG); cmd_commit = (op == OP_CMT); cmd_validate = (op == OP_VAL);
    @(negedge clk);
    cmd_begin = 1'b0; cmd_commit = 1'b0; cmd_validate = 1'b0;
    got = (op == OP_VAL) ? val_valid : (op == OP_CMT) ? cmt_valid : 1'b1;
    res = (op == OP_VAL) ? {val_abort, val_reason} : {2'b00, cmt_ok};
    bc_n = 0;
    while (bc_valid && bc_n < 8) begin
      bc_a[bc_n] = bc_addr; bc_d[bc_n] = bc_data;
      chk("R6", 32'(req_ready), 32'd0, "ready during broadcast");
      bc_n++;
      @(negedge clk);
    end
  endtask

  task automatic snoop(input logic [15:0] a);
    @(negedge clk);
    snp_valid = 1'b1; snp_addr = a;
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic rd_chk(input string rq, input logic wr, input logic [15:0] a, input logic [15:0] d,
                        input logic emiss, input logic [15:0] edata);
    logic m, r;
    logic [15:0] v;
    access(wr, a, d, m, r, v);
    chk(rq, 32'(m), 32'(emiss), "miss");
    chk(rq, 32'(r), 32'd1, "response due");
    chk(rq, 32'(v), 32'(edata), "data");
  endtask

  task automatic cmd_chk(input string rq, input logic [2:0] op, input logic [2:0] eres);
    logic g;
    logic [2:0] r;
    command(op, g, r);
    chk(rq, 32'(g), 32'd1, "answer due");
    chk(rq, 32'(r), 32'(eres), "answer value");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    logic g;
    logic [2:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", 32'(req_ready), 32'd1, "ready after reset");
    chk("R1", {26'd0, rsp_valid, bus_rd_req, bc_valid, val_valid, cmt_valid, 1'b0}, 32'd0, "outputs idle");
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      logic [2:0] op;
      logic [3:0] rn;
      logic [15:0] a, d, ev;
      logic em;
      string rq;
      {op, rn, a, d, em, ev} = VEC[i];
      rq = $sformatf("R%0d", rn);
      case (op)
        OP_RD, OP_WR: rd_chk(rq, op == OP_WR, a, d, em, ev);
        OP_SNP: snoop(a);
        OP_BEG: command(OP_BEG, g, r);
        OP_VAL: cmd_chk(rq, OP_VAL, ev[2:0]);
        default: begin
          cmd_chk(rq, OP_CMT, {2'b00, ev[0]});
          chk(rq, 32'(bc_n), 32'(ev[7:4]), "broadcast count");
        end
      endcase
    end

    // R6 / R12: broadcast follows way order, not write order
    command(OP_BEG, g, r);
    rd_chk("R12", 1'b1, 16'h0050, 16'h5555, 1'b1, 16'h5555);
    rd_chk("R4",  1'b1, 16'h0040, 16'h4040, 1'b0, 16'h4040);
    rd_chk("R4",  1'b1, 16'h0010, 16'h1010, 1'b0, 16'h1010);
    rd_chk("R12", 1'b1, 16'h0060, 16'h6666, 1'b1, 16'h6666);
    cmd_chk("R6", OP_CMT, 3'b001);
    chk("R6", 32'(bc_n), 32'd4, "broadcast count");
    chk("R6", {bc_a[0], bc_d[0]}, {16'h0010, 16'h1010}, "entry way0");
    chk("R12", {bc_a[1], bc_d[1]}, {16'h0050, 16'h5555}, "entry way1");
    chk("R6", {bc_a[2], bc_d[2]}, {16'h0040, 16'h4040}, "entry way2");
    chk("R12", {bc_a[3], bc_d[3]}, {16'h0060, 16'h6666}, "entry way3");

    // R9 capacity abort
    command(OP_BEG, g, r);
    rd_chk("R9", 1'b0, 16'h0010, 16'h0, 1'b0, 16'h1010);
    rd_chk("R9", 1'b0, 16'h0050, 16'h0, 1'b0, 16'h5555);
    rd_chk("R9", 1'b0, 16'h0040, 16'h0, 1'b0, 16'h4040);
    rd_chk("R9", 1'b0, 16'h0060, 16'h0, 1'b0, 16'h6666);
    rd_chk("R9", 1'b0, 16'h0070, 16'h0, 1'b0, 16'h0000);
    cmd_chk("R9", OP_VAL, 3'b110);
    rd_chk("R9", 1'b0, 16'h0010, 16'h0, 1'b1, 16'h5A4A);

    // R12 victim is lowest unflagged way when none is free
    rd_chk("R12", 1'b0, 16'h0080, 16'h0, 1'b1, 16'h5ADA);
    rd_chk("R12", 1'b0, 16'h0090, 16'h0, 1'b1, 16'h5ACA);
    rd_chk("R12", 1'b0, 16'h00A0, 16'h0, 1'b1, 16'h5AFA);
    command(OP_BEG, g, r);
    rd_chk("R12", 1'b0, 16'h0080, 16'h0, 1'b0, 16'h5ADA);
    rd_chk("R12", 1'b1, 16'h00B0, 16'hBBBB, 1'b1, 16'hBBBB);
    cmd_chk("R6", OP_CMT, 3'b001);
    chk("R12", 32'(bc_n), 32'd1, "broadcast count");
    chk("R12", {bc_a[0], bc_d[0]}, {16'h00B0, 16'hBBBB}, "replaced way0");
    rd_chk("R12", 1'b0, 16'h0010, 16'h0, 1'b1, 16'h5A4A);
    rd_chk("R12", 1'b0, 16'h0080, 16'h0, 1'b0, 16'h5ADA);
    cmd_chk("R10", OP_VAL, 3'b000);

    // R1 reset empties the cache
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd_chk("R1", 1'b0, 16'h0080, 16'h0, 1'b1, 16'h5ADA);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule